// File: doc/BRIEF.md
# Windowed Watchdog Timer with Key-Guarded Configuration

This block is a self-contained supervisory timer. A 12-bit down-counter is clocked by a prescaled tick. The tick itself comes from a slow time base that is modelled as the enable input `tick_i`. All control reaches the block as single-cycle writes on a small register port. A key slot takes magic values that start the counter, refresh it, or open and close write access to three configuration slots: tick divider, reload value and window limit.

The block raises a one-cycle reset request in two cases. The first is when the counter runs down to zero. The second is when software refreshes too early, meaning while the count is still above the window limit. Configuration writes do not take effect at once. Each accepted write sets a pending flag, and the new value reaches the counting logic only after a fixed number of tick pulses. The block reports ready only when no update is pending.

Top module: `win_watchdog`

## Requirements
- R1: After reset, count_o reads 0xFFF, status_o is 0, ready_o is 1 and rst_req_o is 0. The configuration slots are locked, and the count stays at 0xFFF until a start key is written.
- R2: Writing 0xCCCC to the key slot (wr_sel_i = 0) loads the counter from the active reload value and starts it. From then on the count drops by one every divider-many tick pulses. The first decrement lands on the divider-th tick after the start write.
- R3: The divider slot (wr_sel_i = 1) keeps the low 3 bits of a write. Code c from 0 to 6 selects a divider of 4·2^c, and code 7 also selects 256.
- R4: Writing 0xAAAA to the key slot while the counter runs reloads the count from the active reload value. Before a start, this key changes nothing.
- R5: Writing 0x5555 to the key slot opens write access to the divider, reload (wr_sel_i = 2) and window (wr_sel_i = 3) slots. Any other key value closes it. Writes to those slots while access is closed set no flag and change no value.
- R6: The reload and window slots keep only the low 12 bits of a write.
- R7: status_o bit 0 is the divider update pending, bit 1 is the reload update pending and bit 2 is the window update pending. An accepted write sets its bit on the next clock, and the bit clears on the 5th tick pulse after the write. The new value is used only from that point. ready_o is 1 exactly when all three bits are 0.
- R8: When the running count reaches zero, rst_req_o is high for exactly one clock, starting one clock after the count reads zero. The count then stays at zero, and start and refresh keys are ignored until reset.
- R9: A refresh while the count is strictly above the window value raises the one-clock rst_req_o instead of reloading. The count is forced to zero and held there. A refresh with the count equal to the window value reloads normally.
- R10: A window value of 0xFFF turns the early-refresh check off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Slow time-base enable, one pulse per tick |
| wr_en_i | input | 1 | Write strobe, one clock per write |
| wr_sel_i | input | 2 | Slot select: 0 key, 1 divider, 2 reload, 3 window |
| wr_data_i | input | 16 | Write data |
| count_o | output | 12 | Current down-counter value |
| status_o | output | 3 | Update-pending flags {window, reload, divider} |
| ready_o | output | 1 | No configuration update pending |
| rst_req_o | output | 1 | One-clock reset request |

## Verification
The refresh decision is tried with a table of reload, window and elapsed-time triples. The triples put the count well above the window, one above it, exactly on it, below it, and under a disabled window, so a wrong comparison, an off-by-one boundary or a missing disable code each produce a different miscompare. Reload writes with high garbage bits show whether masking works. Directed runs count divider steps at two codes, one of them out of range, to expose wrong tick counts. They also cover a refresh issued while a reload update is still pending, which separates a write applied at once from one applied after the pending delay. Expiry runs check the pulse width and confirm that the block stays dead after firing.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    SEL_KEY = 2'd0,
    SEL_PSC = 2'd1,
    SEL_RLD = 2'd2,
    SEL_WIN = 2'd3
  } wdg_sel_e;

  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_UNLOCK  = 16'h5555;
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PSC_W-1:0] code_i,
  output logic             step_o
);
  localparam int CODE_MAX = 2**PSC_W - 2;
  localparam int DIV_W    = CODE_MAX + 2;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;
  logic [PSC_W-1:0] code_eff;

  always_comb begin
    code_eff = (code_i > PSC_W'(CODE_MAX)) ? PSC_W'(CODE_MAX) : code_i;
    // terminal count = 4*2^code - 1
    last     = {DIV_W{1'b1}} >> (CODE_MAX - int'(code_eff));
    step_o   = run_i && tick_i && (cnt_q >= last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= step_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_cfg_slot.sv
module wdg_cfg_slot #(
  parameter int             W          = 12,
  parameter logic [W-1:0]   RST_VAL    = '0,
  parameter int             SYNC_TICKS = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         tick_i,
  output logic [W-1:0] val_o,
  output logic         busy_o
);
  localparam int TW = $clog2(SYNC_TICKS + 1);

  logic [W-1:0]  shadow_q, val_q;
  logic          busy_q;
  logic [TW-1:0] tcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= RST_VAL;
      val_q    <= RST_VAL;
      busy_q   <= 1'b0;
      tcnt_q   <= '0;
    end else if (wr_i) begin
      shadow_q <= data_i;
      busy_q   <= 1'b1;
      tcnt_q   <= '0;
    end else if (busy_q && tick_i) begin
      if (tcnt_q == TW'(SYNC_TICKS - 1)) begin
        val_q  <= shadow_q;
        busy_q <= 1'b0;
        tcnt_q <= '0;
      end else begin
        tcnt_q <= tcnt_q + 1'b1;
      end
    end
  end

  assign val_o  = val_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wdg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int PSC_W      = 3,
  parameter int SYNC_TICKS = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [2:0]        status_o,
  output logic              ready_o,
  output logic              rst_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             key_wr, key_start, key_refresh;
  logic             unlocked_q, running_q, expired_q, req_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_val;
  logic [CNT_W-1:0] rld_val, win_val;
  logic             psc_busy, rld_busy, win_busy;
  logic             step, early;

  assign key_wr      = wr_en_i && (wr_sel_i == SEL_KEY);
  assign key_start   = key_wr && (wr_data_i == KEY_START);
  assign key_refresh = key_wr && (wr_data_i == KEY_REFRESH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     unlocked_q <= 1'b0;
    else if (key_wr) unlocked_q <= (wr_data_i == KEY_UNLOCK);
  end

  wdg_cfg_slot #(.W(PSC_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_psc_slot (
    .clk_i, .rst_ni,
    .wr_i   (wr_en_i && unlocked_q && (wr_sel_i == SEL_PSC)),
    .data_i (wr_data_i[PSC_W-1:0]),
    .tick_i,
    .val_o  (psc_val),
    .busy_o (psc_busy)
  );

  wdg_cfg_slot #(.W(CNT_W), .RST_VAL(CNT_MAX), .SYNC_TICKS(SYNC_TICKS)) u_rld_slot (
    .clk_i, .rst_ni,
    .wr_i   (wr_en_i && unlocked_q && (wr_sel_i == SEL_RLD)),
    .data_i (wr_data_i[CNT_W-1:0]),
    .tick_i,
    .val_o  (rld_val),
    .busy_o (rld_busy)
  );

  wdg_cfg_slot #(.W(CNT_W), .RST_VAL(CNT_MAX), .SYNC_TICKS(SYNC_TICKS)) u_win_slot (
    .clk_i, .rst_ni,
    .wr_i   (wr_en_i && unlocked_q && (wr_sel_i == SEL_WIN)),
    .data_i (wr_data_i[CNT_W-1:0]),
    .tick_i,
    .val_o  (win_val),
    .busy_o (win_busy)
  );

  wdg_prescaler #(.PSC_W(PSC_W)) u_prescaler (
    .clk_i, .rst_ni,
    .clr_i  (key_start && !running_q),
    .run_i  (running_q && !expired_q),
    .tick_i,
    .code_i (psc_val),
    .step_o (step)
  );

  // refresh above an enabled window is a fault
  assign early = (win_val != CNT_MAX) && (cnt_q > win_val);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      expired_q <= 1'b0;
      req_q     <= 1'b0;
      cnt_q     <= CNT_MAX;
    end else begin
      req_q <= 1'b0;
      if (expired_q) begin
        cnt_q <= '0;
      end else if (running_q && key_refresh && early) begin
        req_q     <= 1'b1;
        expired_q <= 1'b1;
        cnt_q     <= '0;
      end else if (running_q && cnt_q == '0) begin
        req_q     <= 1'b1;
        expired_q <= 1'b1;
      end else if (running_q && key_refresh) begin
        cnt_q <= rld_val;
      end else if (!running_q && key_start) begin
        running_q <= 1'b1;
        cnt_q     <= rld_val;
      end else if (step) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign count_o   = cnt_q;
  assign status_o  = {win_busy, rld_busy, psc_busy};
  assign ready_o   = ~|status_o;
  assign rst_req_o = req_q;
endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic [CNT_W-1:0]  count_o,
  input logic [2:0]        status_o,
  input logic              rst_req_o,
  input logic              unlocked_i,
  input logic              running_i,
  input logic              expired_i,
  input logic [CNT_W-1:0]  win_i
);
  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o); // R8

  AST_ZERO_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0) |=> (count_o == '0)); // R8

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_o) |-> ((count_o == $past(count_o) - 1'b1) || (count_o == '0)
                           || $past(wr_en_i && wr_sel_i == SEL_KEY))); // R2

  AST_LOCKED_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i != SEL_KEY && !unlocked_i)
      |=> ($countones(status_o) <= $countones($past(status_o)))); // R5

  AST_EARLY_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == SEL_KEY && wr_data_i == KEY_REFRESH && running_i && !expired_i
     && win_i != {CNT_W{1'b1}} && count_o > win_i)
      |=> (rst_req_o && count_o == '0)); // R9
endmodule

bind win_watchdog win_watchdog_chk #(.CNT_W(CNT_W)) u_win_watchdog_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .wr_data_i  (wr_data_i),
  .count_o    (count_o),
  .status_o   (status_o),
  .rst_req_o  (rst_req_o),
  .unlocked_i (unlocked_q),
  .running_i  (running_q),
  .expired_i  (expired_q),
  .win_i      (win_val)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;
  import wdg_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'd0;
  logic [15:0] wr_data_i = '0;
  logic [11:0] count_o;
  logic [2:0]  status_o;
  logic        ready_o, rst_req_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  win_watchdog u_win_watchdog (.*);

  // {reload write, window write, idle cycles before refresh}
  localparam int NVEC = 9;
  localparam logic [47:0] VEC [NVEC] = '{
    {16'hA0C8, 16'h0FFF, 16'd40},
    {16'h00C8, 16'h0096, 16'd40},
    {16'h00C8, 16'h00BE, 16'd40},
    {16'h00C8, 16'hF0BD, 16'd40},
    {16'h0032, 16'h0FFE, 16'd100},
    {16'h012C, 16'h012B, 16'd3},
    {16'h012C, 16'h012B, 16'd4},
    {16'hFFFF, 16'h0FFE, 16'd0},
    {16'h0FFF, 16'h0FFF, 16'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] data);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] rl, wn, pre;
    logic        viol;
    int          n;
    do_reset();

    // R1 reset state
    check("R1 count", count_o, 12'hFFF);
    check("R1 status", status_o, 3'b000);
    check("R1 ready", ready_o, 1'b1);
    check("R1 req", rst_req_o, 1'b0);

    // R4 refresh before start does nothing; R1 counter stopped
    wr(SEL_KEY, KEY_REFRESH);
    idle(8);
    check("R4 refresh before start", count_o, 12'hFFF);

    // R5 locked writes ignored
    wr(SEL_RLD, 16'd10);
    idle(1);
    check("R5 locked write no flag", status_o, 3'b000);
    wr(SEL_KEY, KEY_START);
    check("R5 locked reload unchanged", count_o, 12'hFFF);

    // R5 non-unlock key relocks
    do_reset();
    wr(SEL_KEY, KEY_UNLOCK);
    wr(SEL_KEY, KEY_REFRESH);
    wr(SEL_WIN, 16'd5);
    idle(1);
    check("R5 relock by other key", status_o, 3'b000);

    // R7 pending flag timing
    do_reset();
    wr(SEL_KEY, KEY_UNLOCK);
    wr(SEL_RLD, 16'd40);
    check("R7 reload pending", status_o, 3'b010);
    check("R7 not ready", ready_o, 1'b0);
    idle(4);
    check("R7 still pending", status_o, 3'b010);
    idle(1);
    check("R7 pending cleared", status_o, 3'b000);
    check("R7 ready", ready_o, 1'b1);

    // R7 new value used only after pending clears
    do_reset();
    wr(SEL_KEY, KEY_START);
    wr(SEL_KEY, KEY_UNLOCK);
    wr(SEL_RLD, 16'd40);
    wr(SEL_KEY, KEY_REFRESH);
    check("R7 old reload while pending", count_o, 12'hFFF);
    idle(6);
    wr(SEL_KEY, KEY_REFRESH);
    check("R4 refresh uses new reload", count_o, 12'd40);

    // R3 code 7 (upper bits masked) behaves as 256
    do_reset();
    wr(SEL_KEY, KEY_UNLOCK);
    wr(SEL_PSC, 16'hFFF7);
    wr(SEL_RLD, 16'd100);
    idle(6);
    check("R3 psc pending cleared", status_o, 3'b000);
    wr(SEL_KEY, KEY_START);
    idle(255);
    check("R3 div256 before step", count_o, 12'd100);
    idle(1);
    check("R3 div256 step", count_o, 12'd99);

    // R3 code 2 divides by 16
    do_reset();
    wr(SEL_KEY, KEY_UNLOCK);
    wr(SEL_PSC, 16'd2);
    wr(SEL_RLD, 16'd100);
    idle(6);
    wr(SEL_KEY, KEY_START);
    idle(47);
    check("R3 div16 count", count_o, 12'd98);
    idle(1);
    check("R3 div16 step", count_o, 12'd97);

    // R8 expiry
    do_reset();
    wr(SEL_KEY, KEY_UNLOCK);
    wr(SEL_RLD, 16'd8);
    idle(6);
    wr(SEL_KEY, KEY_START);
    idle(32);
    check("R8 count at zero", count_o, 12'd0);
    check("R8 no req yet", rst_req_o, 1'b0);
    idle(1);
    check("R8 req pulse", rst_req_o, 1'b1);
    idle(1);
    check("R8 req one cycle", rst_req_o, 1'b0);
    wr(SEL_KEY, KEY_REFRESH);
    wr(SEL_KEY, KEY_START);
    idle(3);
    check("R8 held at zero", count_o, 12'd0);
    check("R8 no second req", rst_req_o, 1'b0);

    // R2 R6 R9 R10 table of refresh cases, divider 4
    for (int i = 0; i < NVEC; i++) begin
      rl   = VEC[i][43:32];
      wn   = VEC[i][27:16];
      n    = int'(VEC[i][15:0]);
      pre  = rl - 12'(n / 4);
      viol = (wn != 12'hFFF) && (pre > wn);
      do_reset();
      wr(SEL_KEY, KEY_UNLOCK);
      wr(SEL_RLD, VEC[i][47:32]);
      wr(SEL_WIN, VEC[i][31:16]);
      idle(6);
      wr(SEL_KEY, KEY_START);
      idle(n);
      check($sformatf("R2 R6 vec%0d count before refresh", i), count_o, pre);
      wr(SEL_KEY, KEY_REFRESH);
      check($sformatf("R9 R10 vec%0d req", i), rst_req_o, viol);
      check($sformatf("R9 R4 vec%0d count after", i), count_o, viol ? 12'd0 : rl);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule